// File: doc/BRIEF.md
# Two-Port Indexed Host Interface for a Security Module

This block connects a byte-wide host I/O bus with two addresses to the core of a security module. Address 0 carries data: command bytes written by the host and response bytes read back. Address 1 returns a status byte when read. When written, it takes single-byte control codes: abort, a marker for the last command byte, and the opening of an indexed register access. The indexed access reaches eight read-only identification bytes. These are four version bytes and a four-character vendor signature, both set by parameters.

Toward the core, command bytes leave on a valid/ready stream tagged with a last flag. Response bytes come back on a second valid/ready stream, and its last flag ends the transaction. On the command stream, data and last are held stable while valid is high and ready is low. The response stream is back-pressured: ready is high only while a transaction is in progress and the response buffer has room. A complete response must fit in the response buffer, because the host cannot drain bytes until the transaction ends. On abort, a one-cycle flush pulse tells the core to drop its own work.

Top module: `secmod_port_if`

## Requirements
- R1: A host read of address 1, outside an indexed access, returns busy in bit 0, data-available in bit 1 and response-error in bit 2, with bits 7..3 zero. After reset this byte is 0x00.
- R2: A write to address 0 while not busy, with the command buffer not full, appends the byte to the command stream with last=0 unless marked by R3. Stream data and last stay stable while valid is high and ready is low.
- R3: Writing 0x04 to address 1 marks the next command byte written to address 0 as last. Accepting that byte sets busy, which is visible from the next cycle.
- R4: Busy stays set until the core delivers a response byte with rsp_last. Busy then clears, and data-available is set while response bytes remain.
- R5: A read of address 0 while data-available is set returns the oldest response byte and removes it. Data-available falls once the last byte is removed. A read of address 0 without data-available returns 0x00 and removes nothing.
- R6: A write to address 0 while busy, or while the command buffer is full, is discarded and sets response-error. Response-error stays set until an abort.
- R7: Writing 0x01 to address 1 aborts. It clears busy, data-available, response-error, both buffers, a pending last marker and any indexed access, and it drives core_flush high for one cycle.
- R8: Writing 0x08 to address 1 opens an indexed access. The next two writes to address 0 give the 16-bit index, high byte first, and are not commands. The next read of address 1 returns the ID byte and ends the access. Index 0x0F00+i (i = 0..7) gives ID_VERSION[8i+7:8i] for i < 4 and ID_SIG[8(7-i)+7:8(7-i)] for i >= 4. Any other index reads 0xFF.
- R9: A write to address 1 after both index bytes is an indexed write. It ends the access and has no other effect; it is never treated as a control code.
- R10: rsp_ready is high only while busy and while the response buffer is not full.
- R11: Any value written to address 1 other than 0x01, 0x04 or 0x08 (outside an indexed access) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_cs | input | 1 | Host access strobe, one access per cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 1 | Port select: 0 data, 1 status/control |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, combinational from the current state |
| cmd_valid | output | 1 | Command byte available |
| cmd_ready | input | 1 | Core takes the command byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final byte of the command |
| rsp_valid | input | 1 | Core offers a response byte |
| rsp_ready | output | 1 | Response byte accepted |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final response byte |
| core_flush | output | 1 | One-cycle pulse after an abort |

## Verification
Host writes and stream transfers act at the clock edge where the strobe or handshake is seen. Their effects on status, read data, the command stream and core_flush are visible in the very next cycle. Reads are combinational from state, so io_rdata is valid in the same cycle as the read strobe. The bench drives every access on a falling edge and samples io_rdata one time unit later, still in that cycle. Results of an access are checked on the falling edge that follows the capturing rising edge, so no check ever races the edge that produced it.

// File: rtl/secmod_pkg.sv
package secmod_pkg;
  localparam logic [7:0] CTL_ABORT = 8'h01;
  localparam logic [7:0] CTL_LAST  = 8'h04;
  localparam logic [7:0] CTL_INDEX = 8'h08;
  localparam int ST_BUSY = 0;
  localparam int ST_AVAIL = 1;
  localparam int ST_ERR = 2;
  typedef enum logic [1:0] {IX_IDLE, IX_HI, IX_LO, IX_READY} idx_state_e;
endpackage

// File: rtl/secmod_fifo.sv
module secmod_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
  end

  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign empty = (wp == rp);
  assign dout  = mem[rp[AW-1:0]];
endmodule

// File: rtl/secmod_id_index.sv
module secmod_id_index
  import secmod_pkg::*;
#(
  parameter logic [15:0] IDX_BASE = 16'h0F00,
  parameter logic [31:0] ID_VERSION = 32'h04030201,
  parameter logic [31:0] ID_SIG = 32'h41424344
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       start,
  input  logic       p0_wr,
  input  logic [7:0] wdata,
  input  logic       p1_access,
  output logic       active,
  output logic       ready,
  output logic [7:0] id_byte
);
  localparam int ID_BYTES = 8;
  idx_state_e state;
  logic [7:0] idx_hi, idx_lo;
  logic [15:0] full_idx, off;
  logic [7:0] id_tab [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_tab
    if (g < 4) begin : g_ver
      assign id_tab[g] = ID_VERSION[8*g +: 8];
    end else begin : g_sig
      assign id_tab[g] = ID_SIG[8*(7-g) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IX_IDLE;
      idx_hi <= '0;
      idx_lo <= '0;
    end else if (clear) begin
      state <= IX_IDLE;
    end else if (start) begin
      state <= IX_HI;
    end else begin
      unique case (state)
        IX_HI:    if (p0_wr) begin idx_hi <= wdata; state <= IX_LO; end
        IX_LO:    if (p0_wr) begin idx_lo <= wdata; state <= IX_READY; end
        IX_READY: if (p1_access) state <= IX_IDLE;
        default:  state <= IX_IDLE;
      endcase
    end
  end

  assign active   = (state == IX_HI) || (state == IX_LO);
  assign ready    = (state == IX_READY);
  assign full_idx = {idx_hi, idx_lo};
  assign off      = full_idx - IDX_BASE;

  always_comb begin
    if ((full_idx >= IDX_BASE) && (off < 16'd8)) id_byte = id_tab[off[2:0]];
    else id_byte = 8'hFF;
  end
endmodule

// File: rtl/secmod_port_if.sv
module secmod_port_if
  import secmod_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RSP_DEPTH = 4,
  parameter logic [15:0] IDX_BASE = 16'h0F00,
  parameter logic [31:0] ID_VERSION = 32'h04030201,
  parameter logic [31:0] ID_SIG = 32'h41424344
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_cs,
  input  logic       io_wr,
  input  logic       io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_data,
  output logic       cmd_last,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  input  logic       rsp_last,
  output logic       core_flush
);
  logic wr0, wr1, rd0, rd1;
  logic idx_active, idx_ready;
  logic [7:0] id_byte;
  logic abort_req, mark_req, idx_start;
  logic cmd_wr, cmd_ok, cmd_bad;
  logic busy, rerr, last_pend, da;
  logic cmd_full, cmd_empty, rsp_full, rsp_empty;
  logic [7:0] rsp_head;
  logic [8:0] cmd_word;
  logic rsp_acc;

  assign wr0 = io_cs && io_wr && !io_addr;
  assign wr1 = io_cs && io_wr && io_addr;
  assign rd0 = io_cs && !io_wr && !io_addr;
  assign rd1 = io_cs && !io_wr && io_addr;

  assign abort_req = wr1 && !idx_ready && (io_wdata == CTL_ABORT);
  assign mark_req  = wr1 && !idx_ready && (io_wdata == CTL_LAST);
  assign idx_start = wr1 && !idx_ready && (io_wdata == CTL_INDEX);

  assign cmd_wr  = wr0 && !idx_active;
  assign cmd_ok  = cmd_wr && !busy && !cmd_full;
  assign cmd_bad = cmd_wr && (busy || cmd_full);

  assign rsp_ready = busy && !rsp_full;
  assign rsp_acc   = rsp_valid && rsp_ready;
  assign da        = !busy && !rsp_empty;

  secmod_id_index #(
    .IDX_BASE(IDX_BASE), .ID_VERSION(ID_VERSION), .ID_SIG(ID_SIG)
  ) u_idx (
    .clk(clk), .rst_n(rst_n), .clear(abort_req), .start(idx_start),
    .p0_wr(wr0), .wdata(io_wdata), .p1_access(rd1 || wr1),
    .active(idx_active), .ready(idx_ready), .id_byte(id_byte)
  );

  secmod_fifo #(.W(9), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .flush(abort_req),
    .push(cmd_ok), .din({last_pend, io_wdata}),
    .pop(cmd_ready), .dout(cmd_word), .full(cmd_full), .empty(cmd_empty)
  );

  secmod_fifo #(.W(8), .DEPTH(RSP_DEPTH)) u_rspq (
    .clk(clk), .rst_n(rst_n), .flush(abort_req),
    .push(rsp_acc), .din(rsp_data),
    .pop(rd0 && da), .dout(rsp_head), .full(rsp_full), .empty(rsp_empty)
  );

  assign cmd_valid = !cmd_empty;
  assign cmd_data  = cmd_word[7:0];
  assign cmd_last  = cmd_word[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rerr       <= 1'b0;
      last_pend  <= 1'b0;
      core_flush <= 1'b0;
    end else if (abort_req) begin
      busy       <= 1'b0;
      rerr       <= 1'b0;
      last_pend  <= 1'b0;
      core_flush <= 1'b1;
    end else begin
      core_flush <= 1'b0;
      if (mark_req) last_pend <= 1'b1;
      if (cmd_ok && last_pend) begin
        busy      <= 1'b1;
        last_pend <= 1'b0;
      end
      if (cmd_bad) rerr <= 1'b1;
      if (rsp_acc && rsp_last) busy <= 1'b0;
    end
  end

  always_comb begin
    if (!io_addr) io_rdata = da ? rsp_head : 8'h00;
    else if (idx_ready) io_rdata = id_byte;
    else begin
      io_rdata = 8'h00;
      io_rdata[ST_BUSY]  = busy;
      io_rdata[ST_AVAIL] = da;
      io_rdata[ST_ERR]   = rerr;
    end
  end
endmodule

// File: rtl/secmod_port_if_chk.sv
module secmod_port_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort_req,
  input logic       wr0,
  input logic       busy,
  input logic       rerr,
  input logic       da,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       cmd_last,
  input logic       rsp_valid,
  input logic       rsp_last
);
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && !rerr && !da)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rerr && !abort_req) |=> rerr); // R6
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr0)); // R3
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort_req)) |-> $past(rsp_valid && rsp_last)); // R4
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort_req) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_last))); // R2
endmodule

bind secmod_port_if secmod_port_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .wr0(wr0),
  .busy(busy), .rerr(rerr), .da(da),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .cmd_last(cmd_last), .rsp_valid(rsp_valid), .rsp_last(rsp_last)
);

// File: tb/secmod_port_if_tb_top.sv
module secmod_port_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h04030201;
  localparam logic [31:0] SIG = 32'h41424344;

  logic clk = 0, rst_n = 0;
  logic io_cs = 0, io_wr = 0, io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic cmd_valid, cmd_ready = 0, cmd_last;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_ready, rsp_last = 0;
  logic [7:0] rsp_data = 0;
  logic core_flush;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secmod_port_if dut_i (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .core_flush(core_flush)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic a, logic [7:0] d);
    @(negedge clk);
    io_cs = 1; io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_cs = 0; io_wr = 0;
  endtask

  task automatic host_rd(logic a, output logic [7:0] d);
    @(negedge clk);
    io_cs = 1; io_wr = 0; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk);
    io_cs = 0;
  endtask

  task automatic pop_cmd(string tag, logic [7:0] d, logic l);
    @(negedge clk);
    chk({tag, " valid"}, int'(cmd_valid), 1);
    chk({tag, " data"}, int'(cmd_data), int'(d));
    chk({tag, " last"}, int'(cmd_last), int'(l));
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
  endtask

  task automatic push_rsp(logic [7:0] d, logic l);
    @(negedge clk);
    chk("R10 rsp_ready while busy", int'(rsp_ready), 1);
    rsp_valid = 1; rsp_data = d; rsp_last = l;
    @(negedge clk);
    rsp_valid = 0; rsp_last = 0;
  endtask

  function automatic logic [7:0] id_exp(int idx);
    int i = idx - 16'h0F00;
    if (i < 0 || i > 7) return 8'hFF;
    if (i < 4) return VER[8*i +: 8];
    return SIG[8*(7-i) +: 8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    host_rd(1, r); chk("R1 reset status", r, 0);
    host_rd(0, r); chk("R5 reset port0", r, 0);
    chk("R2 reset cmd_valid", cmd_valid, 0);
    chk("R10 reset rsp_ready", rsp_ready, 0);

    // Sweep command and response lengths
    for (int nc = 1; nc <= 4; nc++) begin
      for (int nr = 1; nr <= 4; nr++) begin
        for (int k = 0; k < nc - 1; k++) host_wr(0, 8'(16*nc + k));
        host_rd(1, r); chk("R2 not busy before last", r, 0);
        host_wr(1, 8'h04);
        host_wr(0, 8'(16*nc + nc - 1));
        host_rd(1, r); chk("R3 busy after last", r, 8'h01);
        for (int k = 0; k < nc; k++) pop_cmd("R2 cmd", 8'(16*nc + k), k == nc - 1);
        chk("R2 stream empty", cmd_valid, 0);
        for (int k = 0; k < nr; k++) push_rsp(8'(8'hA0 + 16*nr + k), k == nr - 1);
        host_rd(1, r); chk("R4 avail after rsp_last", r, 8'h02);
        chk("R10 no ready after done", rsp_ready, 0);
        for (int k = 0; k < nr; k++) begin
          host_rd(0, r); chk("R5 rsp byte", r, 8'hA0 + 16*nr + k);
        end
        host_rd(1, r); chk("R5 avail falls", r, 0);
        host_rd(0, r); chk("R5 empty read", r, 0);
      end
    end

    // R6 write while busy, R10 full buffer, R7 abort
    host_wr(1, 8'h04); host_wr(0, 8'h77);
    host_wr(0, 8'h99);
    host_rd(1, r); chk("R6 err on busy write", r, 8'h05);
    pop_cmd("R6 only first byte", 8'h77, 1);
    chk("R6 discarded byte", cmd_valid, 0);
    for (int k = 0; k < 4; k++) push_rsp(8'(k), 0);
    @(negedge clk); chk("R10 ready low when full", rsp_ready, 0);
    host_rd(1, r); chk("R6 err sticky", r, 8'h05);
    host_wr(1, 8'h01);
    chk("R7 flush pulse", core_flush, 1);
    @(negedge clk); chk("R7 flush one cycle", core_flush, 0);
    host_rd(1, r); chk("R7 status cleared", r, 0);
    host_rd(0, r); chk("R7 rsp buffer cleared", r, 0);

    // R7 pending last marker cleared
    host_wr(1, 8'h04); host_wr(1, 8'h01); host_wr(0, 8'h33);
    host_rd(1, r); chk("R7 marker cleared no busy", r, 0);
    pop_cmd("R7 marker cleared", 8'h33, 0);

    // R11 unknown control code
    host_wr(1, 8'h55);
    host_rd(1, r); chk("R11 no effect status", r, 0);
    chk("R11 no cmd", cmd_valid, 0);

    // R8 index sweep
    for (int idx = 16'h0EFE; idx <= 16'h0F09; idx++) begin
      host_wr(1, 8'h08);
      host_wr(0, 8'(idx >> 8));
      host_wr(0, 8'(idx));
      host_rd(1, r); chk("R8 id byte", r, id_exp(idx));
      host_rd(1, r); chk("R8 back to status", r, 0);
    end
    chk("R8 index not command", cmd_valid, 0);

    // R9 indexed write is not a control code
    host_wr(1, 8'h04); host_wr(0, 8'h44);
    host_wr(1, 8'h08); host_wr(0, 8'h0F); host_wr(0, 8'h00);
    host_wr(1, 8'h01);
    host_rd(1, r); chk("R9 indexed write ignored", r, 8'h01);
    chk("R9 no flush", core_flush, 0);
    host_wr(1, 8'h01);
    host_rd(1, r); chk("R7 abort after index", r, 0);
    chk("R7 cmd flushed", cmd_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule